// File: doc/BRIEF.md
# Two-Level Breakpoint Trigger

This block watches a processor for debug events and raises a breakpoint. It looks at two streams: the program counter of each retired instruction, marked by a valid strobe, and each data-bus access, marked by its own strobe and carrying an address and a data word. Six comparators look at these streams. Four compare the program counter, one compares the bus address and one compares the bus data. Each comparator holds a value that software writes.

In single-stage mode, any enabled comparator that matches raises a one-cycle breakpoint pulse. In sequential mode, each comparator belongs to either a first stage or a second stage. A first-stage match arms the trigger. A second-stage match on a later cycle then fires the pulse and disarms it. The address comparator can also be made to require a data match on the same access. A command write returns the sequencer to its unarmed state. The core halt, trace capture and the debug link lie outside this block.

Top module: `brkTrigger`

## Requirements
- R1: Registers are written through `cfgWe`/`cfgIdx`/`cfgData`. Indices 0–3 hold the four PC comparator values, index 4 holds the bus-address value, index 5 holds the bus-data value, index 6 holds the control word and index 7 is a command. A written value applies to accesses from the next cycle on.
- R2: PC comparator k (k = 0..3) matches when `pcValid` is 1 and `pc` equals its value. With `pcValid` low, no PC comparator matches.
- R3: When qualification is off, the address comparator (number 4) matches when `busValid` is 1 and `busAddr` equals its value. The data comparator (number 5) matches when `busValid` is 1 and `busData` equals its value. With `busValid` low, neither matches.
- R4: Control bits [5:0] enable comparators 0..5, one bit each. A comparator whose enable bit is 0 never matches.
- R5: Control bit 6 turns on qualification. When it is set, the address comparator matches only if `busData` also equals the data value on the same access, and the data comparator never matches on its own.
- R6: Control bit 7 = 0 selects single-stage mode. Any match raises `brkPulse` for exactly the cycle after the access, and `armed` stays 0.
- R7: Control bit 7 = 1 selects sequential mode. Control bits [13:8] assign comparators 0..5 to stages: 1 means second stage, 0 means first stage. While unarmed, a first-stage match sets `armed` in the next cycle without a pulse, and second-stage matches are ignored.
- R8: While armed, a second-stage match raises `brkPulse` in the next cycle and clears `armed`. First-stage matches while armed change nothing.
- R9: While unarmed, a first-stage and a second-stage match on the same access only arm the trigger. No pulse is produced.
- R10: Writing index 7 with bit 0 = 1 clears `armed` in the next cycle. This takes priority over any match in the same cycle. Writing index 7 with bit 0 = 0 has no effect.
- R11: After reset, `brkPulse` and `armed` are 0 and all registers are zero, so every comparator is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgIdx | input | 3 | Register index |
| cfgData | input | XLEN | Register write data |
| pcValid | input | 1 | Retired PC is valid this cycle |
| pc | input | XLEN | Retired program counter |
| busValid | input | 1 | Bus access is valid this cycle |
| busAddr | input | XLEN | Bus access address |
| busData | input | XLEN | Bus access data |
| brkPulse | output | 1 | Breakpoint event, one cycle wide |
| armed | output | 1 | Sequencer is waiting for a second-stage match |

## Verification
The assertions take for granted that the control word stays steady across any access they reason about. They also assume that a pulse can only follow a cycle in which a PC or bus strobe was high, which means no match is ever fed in through any other path.

The stimulus keeps within these assumptions. Register writes and strobed accesses always go in separate cycles, except for the one case where a command write on the same cycle as a match is the point of the test. The mode is changed only between sequences. The single-stage sweep walks every enable mask against each comparator, and the sequential cases cover arming, firing, matches that coincide on one access, and clearing.

// File: rtl/brkPkg.sv
package brkPkg;
  localparam int NUM_PC      = 4;
  localparam int NUM_CMP     = NUM_PC + 2;
  localparam int IDX_ADDR    = NUM_PC;
  localparam int IDX_DATA    = NUM_PC + 1;
  localparam int IDX_CTRL    = NUM_PC + 2;
  localparam int IDX_CMD     = NUM_PC + 3;
  localparam int REG_IDX_W   = $clog2(NUM_PC + 4);
  localparam int CTRL_QUAL   = NUM_CMP;
  localparam int CTRL_TWO    = NUM_CMP + 1;
  localparam int CTRL_LVL_LO = NUM_CMP + 2;
  localparam int CTRL_W      = CTRL_LVL_LO + NUM_CMP;

  // write strobes from control to datapath
  typedef struct packed {
    logic [NUM_PC-1:0] wrPc;
    logic              wrAddr;
    logic              wrData;
    logic              wrCtrl;
    logic              seqClear;
  } cfgStrobe_t;

  // decoded control word
  typedef struct packed {
    logic [NUM_CMP-1:0] enable;
    logic               qualify;
    logic               twoLevel;
    logic [NUM_CMP-1:0] level2;
  } trigCfg_t;
endpackage

// File: rtl/brkMatchPath.sv
module brkMatchPath import brkPkg::*; #(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strobe,
  input  logic [XLEN-1:0]    cfgData,
  input  logic               pcValid,
  input  logic [XLEN-1:0]    pc,
  input  logic               busValid,
  input  logic [XLEN-1:0]    busAddr,
  input  logic [XLEN-1:0]    busData,
  output logic [NUM_CMP-1:0] hits,
  output trigCfg_t           cfg
);
  logic [XLEN-1:0]   addrCmp;
  logic [XLEN-1:0]   dataCmp;
  logic [CTRL_W-1:0] ctrlReg;
  logic              addrEq;
  logic              dataEq;

  for (genvar g = 0; g < NUM_PC; g++) begin : gPcCmp
    logic [XLEN-1:0] pcCmp;
    always_ff @(posedge clk) begin
      if (!rstN)               pcCmp <= '0;
      else if (strobe.wrPc[g]) pcCmp <= cfgData;
    end
    assign hits[g] = pcValid && (pc == pcCmp) && cfg.enable[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrCmp <= '0;
      dataCmp <= '0;
      ctrlReg <= '0;
    end else begin
      if (strobe.wrAddr) addrCmp <= cfgData;
      if (strobe.wrData) dataCmp <= cfgData;
      if (strobe.wrCtrl) ctrlReg <= cfgData[CTRL_W-1:0];
    end
  end

  assign cfg.enable   = ctrlReg[NUM_CMP-1:0];
  assign cfg.qualify  = ctrlReg[CTRL_QUAL];
  assign cfg.twoLevel = ctrlReg[CTRL_TWO];
  assign cfg.level2   = ctrlReg[CTRL_LVL_LO +: NUM_CMP];

  assign addrEq = (busAddr == addrCmp);
  assign dataEq = (busData == dataCmp);

  assign hits[IDX_ADDR] = busValid && addrEq && cfg.enable[IDX_ADDR] &&
                          (!cfg.qualify || dataEq);
  assign hits[IDX_DATA] = busValid && dataEq && cfg.enable[IDX_DATA] &&
                          !cfg.qualify;
endmodule

// File: rtl/brkSeqCtrl.sv
module brkSeqCtrl import brkPkg::*; (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [REG_IDX_W-1:0] cfgIdx,
  input  logic                 cmdBit,
  input  logic [NUM_CMP-1:0]   hits,
  input  trigCfg_t             cfg,
  output cfgStrobe_t           strobe,
  output logic                 brkPulse,
  output logic                 armed
);
  logic l1Hit;
  logic l2Hit;
  logic anyHit;

  always_comb begin
    strobe = '0;
    for (int i = 0; i < NUM_PC; i++)
      strobe.wrPc[i] = cfgWe && (cfgIdx == REG_IDX_W'(i));
    strobe.wrAddr   = cfgWe && (cfgIdx == REG_IDX_W'(IDX_ADDR));
    strobe.wrData   = cfgWe && (cfgIdx == REG_IDX_W'(IDX_DATA));
    strobe.wrCtrl   = cfgWe && (cfgIdx == REG_IDX_W'(IDX_CTRL));
    strobe.seqClear = cfgWe && (cfgIdx == REG_IDX_W'(IDX_CMD)) && cmdBit;
  end

  assign l1Hit  = |(hits & ~cfg.level2);
  assign l2Hit  = |(hits & cfg.level2);
  assign anyHit = |hits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed    <= 1'b0;
      brkPulse <= 1'b0;
    end else begin
      brkPulse <= 1'b0;
      if (!cfg.twoLevel) begin
        armed    <= 1'b0;
        brkPulse <= anyHit;
      end else if (strobe.seqClear) begin
        armed <= 1'b0;
      end else if (armed) begin
        if (l2Hit) begin
          brkPulse <= 1'b1;
          armed    <= 1'b0;
        end
      end else if (l1Hit) begin
        armed <= 1'b1;
      end
    end
  end

  AST_SINGLE_STAGE_UNARMED: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.twoLevel |=> !armed); // R6
  AST_PULSE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    (brkPulse && $past(cfg.twoLevel)) |-> $past(armed)); // R8
  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.twoLevel && armed && l2Hit && !strobe.seqClear) |=> (brkPulse && !armed)); // R8
  AST_CLEAR_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.seqClear |=> !armed); // R10
endmodule

// File: rtl/brkTrigger.sv
module brkTrigger import brkPkg::*; #(
  parameter int XLEN = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [REG_IDX_W-1:0] cfgIdx,
  input  logic [XLEN-1:0]      cfgData,
  input  logic                 pcValid,
  input  logic [XLEN-1:0]      pc,
  input  logic                 busValid,
  input  logic [XLEN-1:0]      busAddr,
  input  logic [XLEN-1:0]      busData,
  output logic                 brkPulse,
  output logic                 armed
);
  cfgStrobe_t         strobe;
  trigCfg_t           cfg;
  logic [NUM_CMP-1:0] hits;

  brkSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cmdBit(cfgData[0]), .hits(hits), .cfg(cfg),
    .strobe(strobe), .brkPulse(brkPulse), .armed(armed)
  );

  brkMatchPath #(.XLEN(XLEN)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgData(cfgData),
    .pcValid(pcValid), .pc(pc), .busValid(busValid),
    .busAddr(busAddr), .busData(busData), .hits(hits), .cfg(cfg)
  );

  AST_PULSE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    brkPulse |-> $past(pcValid || busValid)); // R2
endmodule

// File: tb/brkTrigger_bench.sv
module brkTrigger_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam logic [31:0] ADDR_V = 32'hA000;
  localparam logic [31:0] DATA_V = 32'h5A5A;

  logic clk = 1'b0;
  logic rstN;
  logic cfgWe;
  logic [2:0] cfgIdx;
  logic [XLEN-1:0] cfgData, pc, busAddr, busData;
  logic pcValid, busValid;
  logic brkPulse, armed;
  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brkTrigger #(.XLEN(XLEN)) u_brkTrigger (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .pcValid(pcValid), .pc(pc), .busValid(busValid), .busAddr(busAddr),
    .busData(busData), .brkPulse(brkPulse), .armed(armed)
  );

  function automatic logic [31:0] pcVal(int k);
    return 32'h1000 + 32'(k) * 32'h10;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wrReg(int idx, logic [31:0] v);
    cfgWe = 1'b1; cfgIdx = idx[2:0]; cfgData = v;
    @(negedge clk);
    cfgWe = 1'b0; cfgData = '0;
  endtask

  task automatic access(logic pv, logic [31:0] p, logic bv, logic [31:0] a, logic [31:0] d);
    pcValid = pv; pc = p; busValid = bv; busAddr = a; busData = d;
    @(negedge clk);
    pcValid = 1'b0; busValid = 1'b0;
  endtask

  task automatic stimCmp(int k);
    if (k < 4)       access(1'b1, pcVal(k), 1'b0, '0, '0);
    else if (k == 4) access(1'b0, '0, 1'b1, ADDR_V, 32'h1111);
    else             access(1'b0, '0, 1'b1, 32'hB000, DATA_V);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgWe = 1'b0; cfgIdx = '0; cfgData = '0;
    pcValid = 1'b0; pc = '0; busValid = 1'b0; busAddr = '0; busData = '0;
    repeat (3) @(negedge clk);
    chk("R11 pulse in reset", brkPulse, 1'b0);
    chk("R11 armed in reset", armed, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    access(1'b1, 32'h0, 1'b1, 32'h0, 32'h0);
    chk("R11 zero regs disabled", brkPulse, 1'b0);

    for (int k = 0; k < 4; k++) wrReg(k, pcVal(k));
    wrReg(4, ADDR_V);
    wrReg(5, DATA_V);

    // single-stage sweep: every enable mask against every comparator
    for (int k = 0; k < 6; k++) begin
      for (int m = 0; m < 64; m++) begin
        wrReg(6, 32'(m));
        stimCmp(k);
        chk($sformatf("R4 cmp%0d mask%0d", k, m), brkPulse, m[k]);
        chk($sformatf("R6 armed cmp%0d mask%0d", k, m), armed, 1'b0);
        @(negedge clk);
        chk($sformatf("R6 width cmp%0d mask%0d", k, m), brkPulse, 1'b0);
      end
    end

    wrReg(6, 32'h3F);
    access(1'b1, pcVal(0) + 1, 1'b0, '0, '0);
    chk("R2 pc mismatch", brkPulse, 1'b0);
    access(1'b0, pcVal(0), 1'b0, '0, '0);
    chk("R2 pcValid low", brkPulse, 1'b0);
    access(1'b0, '0, 1'b0, ADDR_V, DATA_V);
    chk("R3 busValid low", brkPulse, 1'b0);
    access(1'b0, '0, 1'b1, ADDR_V, DATA_V);
    chk("R3 addr and data", brkPulse, 1'b1);

    wrReg(0, 32'h2222);
    access(1'b1, 32'h2222, 1'b0, '0, '0);
    chk("R1 new value", brkPulse, 1'b1);
    access(1'b1, pcVal(0), 1'b0, '0, '0);
    chk("R1 old value", brkPulse, 1'b0);
    wrReg(0, pcVal(0));

    wrReg(6, 32'h3F | (32'h1 << 6));
    access(1'b0, '0, 1'b1, ADDR_V, 32'h1111);
    chk("R5 addr without data", brkPulse, 1'b0);
    access(1'b0, '0, 1'b1, ADDR_V, DATA_V);
    chk("R5 addr with data", brkPulse, 1'b1);
    access(1'b0, '0, 1'b1, 32'hB000, DATA_V);
    chk("R5 data alone", brkPulse, 1'b0);

    // sequential: pc0 first stage, addr second stage
    wrReg(6, 32'h11 | (32'h1 << 7) | (32'h10 << 8));
    access(1'b0, '0, 1'b1, ADDR_V, '0);
    chk("R7 stage2 ignored pulse", brkPulse, 1'b0);
    chk("R7 stage2 ignored armed", armed, 1'b0);
    access(1'b1, pcVal(0), 1'b0, '0, '0);
    chk("R7 arm no pulse", brkPulse, 1'b0);
    chk("R7 armed", armed, 1'b1);
    access(1'b1, pcVal(0), 1'b0, '0, '0);
    chk("R8 stage1 while armed pulse", brkPulse, 1'b0);
    chk("R8 stage1 while armed armed", armed, 1'b1);
    access(1'b0, '0, 1'b1, ADDR_V, '0);
    chk("R8 fire pulse", brkPulse, 1'b1);
    chk("R8 fire disarms", armed, 1'b0);
    @(negedge clk);
    chk("R8 pulse width", brkPulse, 1'b0);

    access(1'b1, pcVal(0), 1'b1, ADDR_V, '0);
    chk("R9 same access pulse", brkPulse, 1'b0);
    chk("R9 same access arms", armed, 1'b1);
    access(1'b0, '0, 1'b1, ADDR_V, '0);
    chk("R9 later fire", brkPulse, 1'b1);

    access(1'b1, pcVal(0), 1'b0, '0, '0);
    wrReg(7, 32'h0);
    chk("R10 zero command ignored", armed, 1'b1);
    wrReg(7, 32'h1);
    chk("R10 clear", armed, 1'b0);
    access(1'b0, '0, 1'b1, ADDR_V, '0);
    chk("R10 no fire after clear", brkPulse, 1'b0);

    cfgWe = 1'b1; cfgIdx = 3'd7; cfgData = 32'h1;
    pcValid = 1'b1; pc = pcVal(0);
    @(negedge clk);
    cfgWe = 1'b0; cfgData = '0; pcValid = 1'b0;
    chk("R10 clear beats arm", armed, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule